// File: doc/BRIEF.md
# Raster Blanking and Controller-Read Status Generator

This block keeps the horizontal and vertical dot position of a raster display and derives three timing flags from that position: a vertical-blank flag, a horizontal-blank flag and a flag that marks the window in which controller data is being gathered automatically. The flags change at fixed positions that sit a few dots away from the line and frame boundaries, not on the boundaries themselves. The read window opens together with vertical blank and spans three scanlines.

The counters move only on clock cycles where the dot enable is high, so the block can run from a fast system clock with a slower pixel rate. A single readable status byte collects the three flags for a processor poll. The serial shifting of controller data and any interrupt generation sit outside this block; only the busy window is produced here.

Top module: `blank_status_gen`

## Requirements
- R1: A synchronous active-high reset sets both counters to 0, clears all three flags and makes the status byte read 0x00.
- R2: The horizontal counter steps by one on every clock edge with the dot enable high, running 0 to 339 and then returning to 0.
- R3: The vertical counter steps by one on each edge where the horizontal counter returns from 339 to 0, running 0 to 261 and then returning to 0.
- R4: On an edge with the dot enable low, both counters and all three flags keep their values.
- R5: The horizontal-blank flag goes high on the edge where the horizontal counter becomes 0x121 (289). It goes low on the edge where the horizontal counter becomes 0x12 (18). This holds on every line.
- R6: The vertical-blank flag goes high on the edge where the position becomes vertical 0xE1 (225), horizontal 0x16 (22). It goes low on the edge where the position becomes vertical 0, horizontal 0x1E (30).
- R7: If the auto-read enable is high on the edge where vertical blank goes high, the busy flag goes high on that same edge. The busy flag goes low on the edge where the position becomes vertical 0xE4 (228), horizontal 0x16. That is three scanlines later.
- R8: If the auto-read enable is low on the edge where vertical blank goes high, the busy flag stays low for the whole frame. This holds even if the enable is raised later in that frame.
- R9: The status byte carries vertical blank in bit 7, horizontal blank in bit 6 and the busy flag in bit 0. Bits 5 to 1 read as 0. It follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot enable; counters and flags advance only when high |
| autoread_en | input | 1 | Allows the busy window to open at the next vertical-blank start |
| h_count | output | 9 | Horizontal dot position |
| v_count | output | 9 | Vertical line position |
| vblank | output | 1 | Vertical-blank flag |
| hblank | output | 1 | Horizontal-blank flag |
| autoread_busy | output | 1 | Controller auto-read window active |
| status | output | 8 | Packed status byte |

## Verification
Counters and flags are registered together. Each one reflects the effect of a dot-enabled edge right after that edge. The status byte is combinational from the flags and adds no further delay. The bench drives inputs at the falling edge and compares every output against a behavioural position model at the next falling edge, so each result is checked exactly one rising edge after the stimulus that caused it. The directed checks for hold, flag transitions and the suppressed read window are sampled in the same way, at the first falling edge after the edge that produces the position being tested.

// File: rtl/blank_status_pkg.sv
package blank_status_pkg;

    localparam int unsigned CNT_W  = 9;
    localparam int unsigned NFLAG  = 3;

    // Flag slot indices inside the flag vector
    localparam int unsigned FL_VB   = 0;
    localparam int unsigned FL_HB   = 1;
    localparam int unsigned FL_BUSY = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t v;
        cnt_t h;
    } raster_pos_t;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    function automatic logic pos_is(raster_pos_t p, int unsigned v, int unsigned h);
        return (p.v == cnt_t'(v)) && (p.h == cnt_t'(h));
    endfunction

    function automatic logic [7:0] pack_status(logic vb, logic hb, logic busy);
        return {vb, hb, 5'b0_0000, busy};
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import blank_status_pkg::*;
#(
    parameter int unsigned H_TOTAL = 340,
    parameter int unsigned V_TOTAL = 262
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output raster_pos_t cur,
    output raster_pos_t nxt
);
    localparam cnt_t H_LAST = cnt_t'(H_TOTAL - 1);
    localparam cnt_t V_LAST = cnt_t'(V_TOTAL - 1);

    always_comb begin
        nxt = cur;
        if (step) begin
            if (cur.h == H_LAST) begin
                nxt.h = '0;
                nxt.v = (cur.v == V_LAST) ? '0 : cur.v + 1'b1;
            end else begin
                nxt.h = cur.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/blank_event_decode.sv
module blank_event_decode
    import blank_status_pkg::*;
#(
    parameter int unsigned V_TOTAL    = 262,
    parameter int unsigned HB_SET_H   = 289,
    parameter int unsigned HB_CLR_H   = 18,
    parameter int unsigned VB_SET_V   = 225,
    parameter int unsigned VB_SET_H   = 22,
    parameter int unsigned VB_CLR_V   = 0,
    parameter int unsigned VB_CLR_H   = 30,
    parameter int unsigned AUTO_LINES = 3
) (
    input  logic                  step,
    input  logic                  autoread_en,
    input  raster_pos_t           nxt,
    output flag_evt_t [NFLAG-1:0] evt
);
    localparam int unsigned BUSY_END_V = (VB_SET_V + AUTO_LINES) % V_TOTAL;

    logic vb_start;

    always_comb begin
        vb_start            = step && pos_is(nxt, VB_SET_V, VB_SET_H);

        evt[FL_VB].set      = vb_start;
        evt[FL_VB].clr      = step && pos_is(nxt, VB_CLR_V, VB_CLR_H);

        evt[FL_HB].set      = step && (nxt.h == cnt_t'(HB_SET_H));
        evt[FL_HB].clr      = step && (nxt.h == cnt_t'(HB_CLR_H));

        // Busy window opens only when the enable is present at blank start
        evt[FL_BUSY].set    = vb_start && autoread_en;
        evt[FL_BUSY].clr    = step && pos_is(nxt, BUSY_END_V, VB_SET_H);
    end
endmodule

// File: rtl/sr_flag.sv
module sr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/blank_status_gen.sv
module blank_status_gen
    import blank_status_pkg::*;
#(
    parameter int unsigned H_TOTAL    = 340,
    parameter int unsigned V_TOTAL    = 262,
    parameter int unsigned HB_SET_H   = 289,
    parameter int unsigned HB_CLR_H   = 18,
    parameter int unsigned VB_SET_V   = 225,
    parameter int unsigned VB_SET_H   = 22,
    parameter int unsigned VB_CLR_V   = 0,
    parameter int unsigned VB_CLR_H   = 30,
    parameter int unsigned AUTO_LINES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dot_en,
    input  logic             autoread_en,
    output logic [CNT_W-1:0] h_count,
    output logic [CNT_W-1:0] v_count,
    output logic             vblank,
    output logic             hblank,
    output logic             autoread_busy,
    output logic [7:0]       status
);
    raster_pos_t           pos_cur;
    raster_pos_t           pos_nxt;
    flag_evt_t [NFLAG-1:0] evt;
    logic      [NFLAG-1:0] flag_q;

    raster_counter #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .step (dot_en),
        .cur  (pos_cur),
        .nxt  (pos_nxt)
    );

    blank_event_decode #(
        .V_TOTAL    (V_TOTAL),
        .HB_SET_H   (HB_SET_H),
        .HB_CLR_H   (HB_CLR_H),
        .VB_SET_V   (VB_SET_V),
        .VB_SET_H   (VB_SET_H),
        .VB_CLR_V   (VB_CLR_V),
        .VB_CLR_H   (VB_CLR_H),
        .AUTO_LINES (AUTO_LINES)
    ) u_dec (
        .step        (dot_en),
        .autoread_en (autoread_en),
        .nxt         (pos_nxt),
        .evt         (evt)
    );

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        sr_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (evt[gi].set),
            .clr (evt[gi].clr),
            .q   (flag_q[gi])
        );
    end

    assign h_count       = pos_cur.h;
    assign v_count       = pos_cur.v;
    assign vblank        = flag_q[FL_VB];
    assign hblank        = flag_q[FL_HB];
    assign autoread_busy = flag_q[FL_BUSY];
    assign status        = pack_status(vblank, hblank, autoread_busy);
endmodule

// File: rtl/blank_status_chk.sv
module blank_status_chk
    import blank_status_pkg::*;
#(
    parameter int unsigned H_TOTAL    = 340,
    parameter int unsigned V_TOTAL    = 262,
    parameter int unsigned HB_SET_H   = 289,
    parameter int unsigned HB_CLR_H   = 18,
    parameter int unsigned VB_SET_V   = 225,
    parameter int unsigned VB_SET_H   = 22,
    parameter int unsigned VB_CLR_V   = 0,
    parameter int unsigned VB_CLR_H   = 30,
    parameter int unsigned AUTO_LINES = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       dot_en,
    input logic       autoread_en,
    input cnt_t       h_count,
    input cnt_t       v_count,
    input logic       vblank,
    input logic       hblank,
    input logic       autoread_busy
);
    localparam cnt_t H_LAST  = cnt_t'(H_TOTAL - 1);
    localparam cnt_t V_LAST  = cnt_t'(V_TOTAL - 1);
    localparam cnt_t HB_S    = cnt_t'(HB_SET_H);
    localparam cnt_t HB_C    = cnt_t'(HB_CLR_H);
    localparam cnt_t VB_SV   = cnt_t'(VB_SET_V);
    localparam cnt_t VB_SH   = cnt_t'(VB_SET_H);
    localparam cnt_t VB_CV   = cnt_t'(VB_CLR_V);
    localparam cnt_t VB_CH   = cnt_t'(VB_CLR_H);
    localparam cnt_t BUSY_EV = cnt_t'((VB_SET_V + AUTO_LINES) % V_TOTAL);

    AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
        (dot_en && h_count != H_LAST) |=> h_count == $past(h_count) + 1'b1); // R2
    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dot_en && h_count == H_LAST) |=> h_count == '0); // R2
    AST_V_STEP: assert property (@(posedge clk) disable iff (rst)
        (dot_en && h_count == H_LAST) |=>
        v_count == (($past(v_count) == V_LAST) ? '0 : $past(v_count) + 1'b1)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dot_en |=> ($stable(h_count) && $stable(v_count) && $stable(vblank)
                     && $stable(hblank) && $stable(autoread_busy))); // R4
    AST_HB_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(hblank) |-> h_count == HB_S); // R5
    AST_HB_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(hblank) |-> h_count == HB_C); // R5
    AST_VB_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank) |-> (v_count == VB_SV && h_count == VB_SH)); // R6
    AST_VB_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(vblank) |-> (v_count == VB_CV && h_count == VB_CH)); // R6
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(autoread_busy) |-> ($rose(vblank) && $past(autoread_en))); // R8
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(autoread_busy) |-> (v_count == BUSY_EV && h_count == VB_SH)); // R7
    AST_BUSY_IN_VB: assert property (@(posedge clk) disable iff (rst)
        autoread_busy |-> vblank); // R7
endmodule

bind blank_status_gen blank_status_chk #(
    .H_TOTAL    (H_TOTAL),
    .V_TOTAL    (V_TOTAL),
    .HB_SET_H   (HB_SET_H),
    .HB_CLR_H   (HB_CLR_H),
    .VB_SET_V   (VB_SET_V),
    .VB_SET_H   (VB_SET_H),
    .VB_CLR_V   (VB_CLR_V),
    .VB_CLR_H   (VB_CLR_H),
    .AUTO_LINES (AUTO_LINES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dot_en        (dot_en),
    .autoread_en   (autoread_en),
    .h_count       (h_count),
    .v_count       (v_count),
    .vblank        (vblank),
    .hblank        (hblank),
    .autoread_busy (autoread_busy)
);

// File: tb/blank_status_gen_tb.sv
module blank_status_gen_tb;
    localparam int HT = 340;
    localparam int VT = 262;
    localparam int WATCHDOG = 195000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dot_en = 1'b0;
    logic       autoread_en = 1'b0;
    logic [8:0] h_count;
    logic [8:0] v_count;
    logic       vblank;
    logic       hblank;
    logic       autoread_busy;
    logic [7:0] status;

    int n_checks = 0;
    int n_errors = 0;
    int n_print  = 0;
    bit armed    = 0;
    bit done     = 0;

    // behavioural position model
    int m_h = 0, m_v = 0;
    int m_hb = 0, m_vb = 0, m_busy = 0;

    always #10 clk = ~clk; // 50 MHz

    blank_status_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .dot_en        (dot_en),
        .autoread_en   (autoread_en),
        .h_count       (h_count),
        .v_count       (v_count),
        .vblank        (vblank),
        .hblank        (hblank),
        .autoread_busy (autoread_busy),
        .status        (status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            if (n_print < 40) begin
                n_print++;
                $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_h = 0; m_v = 0; m_hb = 0; m_vb = 0; m_busy = 0;
        end else if (dot_en) begin
            m_h = m_h + 1;
            if (m_h == HT) begin
                m_h = 0;
                m_v = m_v + 1;
                if (m_v == VT) m_v = 0;
            end
            if (m_h == 289) m_hb = 1;
            else if (m_h == 18) m_hb = 0;
            if (m_v == 225 && m_h == 22) begin
                m_vb = 1;
                if (autoread_en) m_busy = 1;
            end
            if (m_v == 0 && m_h == 30) m_vb = 0;
            if (m_v == 228 && m_h == 22) m_busy = 0;
        end
        armed = 1;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(int'(h_count) == m_h, "R2 h_count", int'(h_count), m_h);
            chk(int'(v_count) == m_v, "R3 v_count", int'(v_count), m_v);
            chk(int'(hblank) == m_hb, "R5 hblank", int'(hblank), m_hb);
            chk(int'(vblank) == m_vb, "R6 vblank", int'(vblank), m_vb);
            chk(int'(autoread_busy) == m_busy, "R7 busy", int'(autoread_busy), m_busy);
            chk(int'(status) == (m_vb * 128 + m_hb * 64 + m_busy), "R9 status",
                int'(status), m_vb * 128 + m_hb * 64 + m_busy);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic wait_until_v(input int v);
        while (int'(v_count) != v) @(negedge clk);
    endtask

    initial begin
        int sav_h, sav_v, sav_st;
        bit was_off;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(h_count == 0 && v_count == 0, "R1 counters", int'(h_count) + int'(v_count), 0);
        chk(status == 8'h00, "R1 status", int'(status), 0);
        rst = 1'b0;

        // R4: gated dot enable holds state
        was_off = 0; sav_h = 0; sav_v = 0; sav_st = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (was_off) begin
                chk(int'(h_count) == sav_h && int'(v_count) == sav_v, "R4 counters hold",
                    int'(h_count), sav_h);
                chk(int'(status) == sav_st, "R4 flags hold", int'(status), sav_st);
            end
            dot_en = (i % 3 != 0);
            was_off = !dot_en;
            sav_h = int'(h_count); sav_v = int'(v_count); sav_st = int'(status);
        end
        @(negedge clk);
        dot_en = 1'b1;

        // R8: enable low at blank start suppresses the window
        while (!vblank) @(negedge clk);
        chk(autoread_busy == 1'b0, "R8 busy at blank start", int'(autoread_busy), 0);
        autoread_en = 1'b1;
        wait_until_v(226);
        chk(autoread_busy == 1'b0, "R8 busy after late enable", int'(autoread_busy), 0);
        wait_until_v(229);
        chk(autoread_busy == 1'b0, "R8 busy end of window", int'(autoread_busy), 0);

        // next frame: enable high at blank start
        while (vblank) @(negedge clk);
        chk(int'(v_count) == 0 && int'(h_count) == 30, "R6 clear position",
            int'(h_count), 30);
        while (!vblank) @(negedge clk);
        chk(int'(v_count) == 225 && int'(h_count) == 22, "R6 set position",
            int'(h_count), 22);
        chk(autoread_busy == 1'b1, "R7 busy rises with blank", int'(autoread_busy), 1);
        chk(status[7] == 1'b1 && status[0] == 1'b1 && status[5:1] == 5'd0, "R9 bit layout",
            int'(status), 128 + 64 * int'(hblank) + 1);
        wait_until_v(227);
        chk(autoread_busy == 1'b1, "R7 busy mid window", int'(autoread_busy), 1);
        while (!(int'(v_count) == 228 && int'(h_count) == 22)) @(negedge clk);
        chk(autoread_busy == 1'b0, "R7 busy falls after three lines", int'(autoread_busy), 0);

        // R5: horizontal blank edges
        while (int'(h_count) != 289) @(negedge clk);
        chk(hblank == 1'b1, "R5 set at 0x121", int'(hblank), 1);
        while (int'(h_count) != 18) @(negedge clk);
        chk(hblank == 1'b0, "R5 clear at 0x12", int'(hblank), 0);
        chk(int'(v_count) == 229, "R3 line advance", int'(v_count), 229);

        // R1: reset while vertical blank is active
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(h_count == 0 && v_count == 0, "R1 counters after run", int'(h_count), 0);
        chk(status == 8'h00, "R1 status after run", int'(status), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule